// File: doc/BRIEF.md
# Masked Parallel Priority Interrupt Controller

This block collects interrupt requests from four sources and presents one interrupt line to a processor. Each source has a pending latch that its event sets and that only a software clear write removes. A mask register the same width as the pending latches decides which requests may compete. The unmasked requests feed a fixed-priority encoder. The encoder loads a status flop and a 2-bit code. The processor line is the status flop gated by a global enable flop that software controls.

When the processor acknowledges, the block drives a vector onto its data output. The vector is a fixed upper base field followed by the encoder code. Software changes the mask, clears pending bits and turns the global enable on or off through four separate write strobes. All four strobes share one 4-bit operand.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the pending, mask, enable and status state are all zero, `irq` is 0 and `data_out` is 0.
- R2: A high bit of `src_evt` sets the matching pending bit on the next clock edge. A pending bit clears only through `wr_pend_clr` with the matching `wr_data` bit high. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R3: `wr_mask_set` sets the mask bits that are high in `wr_data`, and `wr_mask_clr` clears them. If both strobes name the same bit in the same cycle, the bit ends up set.
- R4: A pending bit whose mask bit is 0 has no effect on `irq` or on the vector.
- R5: Bit 0 has the highest priority and bit 3 the lowest. The code is the index of the highest-priority bit that is both pending and unmasked, and it is 0 when no such bit exists.
- R6: The status flop and the code register load one clock edge after the pending or mask registers change. The status flop is 1 exactly when some unmasked pending bit existed in the previous cycle.
- R7: `wr_en` loads the global enable from `wr_data[0]`, where 1 enables and 0 disables. `irq` equals the status flop ANDed with the enable.
- R8: While `inta` is high, `data_out` is `{VEC_BASE, code}`. With the default base of 6'h15, the vector is 0x54 plus the code. While `inta` is low, `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_evt | input | NSRC | Per-source request events |
| wr_mask_set | input | 1 | Strobe that sets mask bits named by wr_data |
| wr_mask_clr | input | 1 | Strobe that clears mask bits named by wr_data |
| wr_pend_clr | input | 1 | Strobe that clears pending bits named by wr_data |
| wr_en | input | 1 | Strobe that loads the global enable from wr_data[0] |
| wr_data | input | NSRC | Operand shared by all write strobes |
| inta | input | 1 | Interrupt acknowledge from the processor |
| irq | output | 1 | Interrupt line to the processor |
| data_out | output | VEC_W | Vector while acknowledged, zero otherwise |

## Verification
The assertions allow any mix of strobes, events and acknowledge in any cycle, including several strobes in one cycle. They assume only that reset is held low for at least one clock edge before activity starts. The random stimulus drives every strobe, event and acknowledge independently and often collides a set with a clear on the same bit. Directed sequences then walk the priority order and exercise the same-cycle collision rules.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC = 4,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-$clog2(NSRC)-1:0] VEC_BASE = 'h15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_evt,
  input  logic             wr_mask_set,
  input  logic             wr_mask_clr,
  input  logic             wr_pend_clr,
  input  logic             wr_en,
  input  logic [NSRC-1:0]  wr_data,
  input  logic             inta,
  output logic             irq,
  output logic [VEC_W-1:0] data_out
);
  localparam int CW = $clog2(NSRC);

  logic [NSRC-1:0] pend_q, mask_q, live;
  logic            ien_q, ist_q;
  logic [CW-1:0]   code_q, code_d;

  assign live = pend_q & mask_q;

  always_comb begin
    code_d = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (live[i]) code_d = CW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      ien_q  <= 1'b0;
      ist_q  <= 1'b0;
      code_q <= '0;
    end else begin
      pend_q <= (pend_q & ~(wr_pend_clr ? wr_data : '0)) | src_evt;
      mask_q <= (mask_q & ~(wr_mask_clr ? wr_data : '0)) | (wr_mask_set ? wr_data : '0);
      if (wr_en) ien_q <= wr_data[0];
      ist_q  <= |live;
      code_q <= code_d;
    end
  end

  assign irq      = ist_q & ien_q;
  assign data_out = inta ? {VEC_BASE, code_q} : '0;
endmodule

module prio_irq_ctrl_chk #(
  parameter int NSRC = 4,
  parameter int CW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_evt,
  input logic            wr_mask_set,
  input logic            wr_en,
  input logic [NSRC-1:0] wr_data,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic [CW-1:0]   code_q,
  input logic            ist_q,
  input logic            irq
);
  function automatic logic prio_ok(logic [NSRC-1:0] v, logic [CW-1:0] c);
    logic ok;
    ok = v[c];
    for (int i = 0; i < NSRC; i++)
      if (i < int'(c) && v[i]) ok = 1'b0;
    return ok;
  endfunction

  AST_EVT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((pend_q & $past(src_evt)) == $past(src_evt))); // R2
  AST_MASK_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_set |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R3
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(pend_q & mask_q))); // R6
  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> !irq); // R7
  AST_CODE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    ist_q |-> prio_ok($past(pend_q & mask_q), code_q)); // R5
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_mask_set(wr_mask_set),
  .wr_en(wr_en), .wr_data(wr_data), .pend_q(pend_q), .mask_q(mask_q),
  .code_q(code_q), .ist_q(ist_q), .irq(irq)
);

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] src_evt = '0, wr_data = '0;
  logic wr_mask_set = 0, wr_mask_clr = 0, wr_pend_clr = 0, wr_en = 0, inta = 0;
  logic irq;
  logic [7:0] data_out;
  int n_run = 0, n_fail = 0;
  bit auto_on = 0;

  logic [3:0] m_pend, m_mask;
  logic m_ien, m_ist;
  logic [1:0] m_code;

  always #4 clk = ~clk;

  prio_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .src_evt(src_evt),
    .wr_mask_set(wr_mask_set), .wr_mask_clr(wr_mask_clr), .wr_pend_clr(wr_pend_clr),
    .wr_en(wr_en), .wr_data(wr_data), .inta(inta), .irq(irq), .data_out(data_out));

  function automatic logic [1:0] top_idx(logic [3:0] v);
    if (v[0]) return 2'd0;
    if (v[1]) return 2'd1;
    if (v[2]) return 2'd2;
    if (v[3]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [7:0] exp_bus(logic a, logic [1:0] c);
    return a ? {6'h15, c} : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= '0; m_mask <= '0; m_ien <= 0; m_ist <= 0; m_code <= '0;
    end else begin
      m_pend <= (m_pend & ~(wr_pend_clr ? wr_data : 4'h0)) | src_evt;
      m_mask <= (m_mask & ~(wr_mask_clr ? wr_data : 4'h0)) | (wr_mask_set ? wr_data : 4'h0);
      if (wr_en) m_ien <= wr_data[0];
      m_ist  <= |(m_pend & m_mask);
      m_code <= top_idx(m_pend & m_mask);
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (auto_on && rst_n) begin
    check("R7", {7'd0, irq}, {7'd0, m_ist & m_ien});
    check("R8", data_out, exp_bus(inta, m_code));
  end

  task automatic idle();
    src_evt = '0; wr_mask_set = 0; wr_mask_clr = 0; wr_pend_clr = 0; wr_en = 0; wr_data = '0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    inta = 1;
    cyc(3);
    rst_n = 1;
    cyc(1);
    check("R1", {7'd0, irq}, 8'd0);
    inta = 0;
    #1 check("R1", data_out, 8'h00);
    auto_on = 1;

    wr_en = 1; wr_data = 4'h1; cyc(1); idle();
    src_evt = 4'hF; cyc(1); idle(); cyc(3);
    check("R4", {7'd0, irq}, 8'd0);
    wr_mask_set = 1; wr_data = 4'b0100; cyc(1); idle(); cyc(1);
    inta = 1; #1;
    check("R4", {7'd0, irq}, 8'd1);
    check("R5", data_out, 8'h56);
    wr_mask_set = 1; wr_mask_clr = 1; wr_data = 4'b0010; cyc(1); idle(); cyc(1); #1;
    check("R3", data_out, 8'h55);
    wr_mask_set = 1; wr_data = 4'hF; cyc(1); idle(); cyc(1); #1;
    check("R5", data_out, 8'h54);
    wr_pend_clr = 1; wr_data = 4'b0001; src_evt = 4'b0001; cyc(1); idle(); cyc(1); #1;
    check("R2", data_out, 8'h54);
    wr_pend_clr = 1; wr_data = 4'b0011; cyc(1); idle(); cyc(1); #1;
    check("R5", data_out, 8'h56);
    wr_en = 1; wr_data = 4'h0; cyc(1); idle(); #1;
    check("R7", {7'd0, irq}, 8'd0);
    wr_en = 1; wr_data = 4'h1; cyc(1); idle(); #1;
    check("R7", {7'd0, irq}, 8'd1);
    wr_pend_clr = 1; wr_data = 4'hF; cyc(1); idle(); #1;
    check("R6", {7'd0, irq}, 8'd1);
    cyc(1); #1;
    check("R6", {7'd0, irq}, 8'd0);
    check("R5", data_out, 8'h54);
    inta = 0; #1;
    check("R8", data_out, 8'h00);

    void'($urandom(32'd2468));
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      src_evt     = ($urandom % 6 == 0) ? 4'($urandom) : 4'h0;
      wr_data     = 4'($urandom);
      wr_mask_set = ($urandom % 5 == 0);
      wr_mask_clr = ($urandom % 5 == 0);
      wr_pend_clr = ($urandom % 4 == 0);
      wr_en       = ($urandom % 9 == 0);
      inta        = ($urandom % 2 == 0);
    end
    @(negedge clk); #1; idle(); inta = 0;
    cyc(2);
    auto_on = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule